// File: doc/BRIEF.md
# Receive Frame Flag and Error Checker

This block sits after the line decoder on the receive side of a serial link. Each decoded frame reaches it as one beat on a valid/ready input stream. A beat carries the frame kind (data, control, fill or a reserved code), the frame's internal flag bit and the decoder's invalid-code indication. For each accepted frame, the block produces one beat on a valid/ready output stream. That beat carries the user flag and a one-frame error pulse.

When the flag bit is not needed as a user bit, the block can be switched into alternation-check mode. In that mode the flag must toggle from one data frame to the next, and a repeated value counts as an extra error. Fill and control frames between data frames do not move the expected value. After any error, or after reset, the check restarts from the next data frame.

The block also keeps a frame-lock status. It samples a lock-good input once for every accepted frame. A single bad sample drops the status at once. The status returns only after a run of good samples.

Back-pressure works as follows. The input is accepted when the output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output beat holds still and no new frame is taken.

Top module: `rx_frame_checker`

## Requirements
- R1: After reset, `out_valid`, `out_flag`, `out_error` and `locked` are all 0, and `in_ready` is 1.
- R2: A frame accepted with `in_code_err` = 1 appears one cycle later as an output beat with `out_error` = 1.
- R3: A fill frame (`in_kind` = 2'b10) or a control frame (`in_kind` = 2'b01) gives `out_flag` = 0, whatever `in_flag` is.
- R4: A data frame (`in_kind` = 2'b00) gives `out_flag` equal to its `in_flag`.
- R5: With `alt_check_en` = 1, a data frame raises `out_error` when its flag equals the flag of the previous counted data frame. With `alt_check_en` = 0, no such error is raised.
- R6: Fill and control frames leave the expected flag value unchanged. A repeat across them is still an error, and a proper toggle across them is not.
- R7: The first data frame after reset, after any frame with `out_error` = 1, or after a period with `alt_check_en` = 0, is not checked for alternation. It sets the reference value instead.
- R8: `out_error` covers only the beat of the frame that caused it. The next clean frame gives `out_error` = 0.
- R9: An accepted frame with `lock_ok` = 0 clears `locked` on the next cycle. `locked` is set again only after RELOCK_FRAMES (default 2) consecutive accepted frames with `lock_ok` = 1, so it stays low for at least two frames.
- R10: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and `out_valid`, `out_flag` and `out_error` hold their values.
- R11: A reserved-kind frame (`in_kind` = 2'b11) gives `out_error` = 1 and `out_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_check_en | input | 1 | 1 = the flag is unused and is checked for alternation |
| in_valid | input | 1 | Decoded frame present |
| in_ready | output | 1 | Block accepts the frame this cycle |
| in_kind | input | 2 | Frame kind: 00 data, 01 control, 10 fill, 11 reserved |
| in_flag | input | 1 | Internal flag bit of the frame |
| in_code_err | input | 1 | Decoder found an invalid code in the frame |
| lock_ok | input | 1 | Lock sample for this frame is proper |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result beat |
| out_flag | output | 1 | User flag |
| out_error | output | 1 | Frame error pulse |
| locked | output | 1 | Frame lock status |

## Verification
Several things can land on the same frame: a code error, an alternation repeat and a lock-bad sample, and any of them can arrive while the output is stalled. In that case the resync of the expected flag must follow the combined error, and the lock filter must sample only frames that are actually accepted. The bench provokes these cases with directed frames that carry both a code error and a repeated flag, then with a long pseudo-random stream in which `out_ready`, `lock_ok` and the frame fields change together. Every cycle, it compares the ports against a behavioural model of the flag, error and lock rules.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  typedef enum logic [1:0] {
    FK_DATA = 2'b00,
    FK_CTRL = 2'b01,
    FK_FILL = 2'b10,
    FK_RSVD = 2'b11
  } frame_kind_e;
endpackage

// File: rtl/rxfc_parity.sv
module rxfc_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic alt_en,
  input  logic is_data,
  input  logic flag,
  input  logic other_err,
  output logic repeat_err
);
  logic have_ref;
  logic last_flag;

  // Repeat is flagged only when a reference exists and the mode is on.
  always_comb repeat_err = alt_en && is_data && have_ref && (flag == last_flag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_ref  <= 1'b0;
      last_flag <= 1'b0;
    end else if (fire) begin
      if (!alt_en || other_err || repeat_err) begin
        have_ref <= 1'b0;
      end else if (is_data) begin
        have_ref  <= 1'b1;
        last_flag <= flag;
      end
    end
  end
endmodule

// File: rtl/rxfc_lock.sv
module rxfc_lock #(
  parameter int RELOCK_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic lock_ok,
  output logic locked
);
  localparam int CW = $clog2(RELOCK_FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(RELOCK_FRAMES - 1);

  logic [CW-1:0] good_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      good_cnt <= '0;
    end else if (fire) begin
      if (!lock_ok) begin
        locked   <= 1'b0;
        good_cnt <= '0;
      end else if (!locked) begin
        if (good_cnt == LAST) begin
          locked   <= 1'b1;
          good_cnt <= '0;
        end else begin
          good_cnt <= good_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxfc_out_stage.sv
module rxfc_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic nxt_flag,
  input  logic nxt_error,
  output logic out_valid,
  input  logic out_ready,
  output logic out_flag,
  output logic out_error
);
  always_comb in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flag  <= 1'b0;
      out_error <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_flag  <= nxt_flag;
      out_error <= nxt_error;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
  import rxfc_pkg::*;
#(
  parameter int RELOCK_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_check_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_kind,
  input  logic       in_flag,
  input  logic       in_code_err,
  input  logic       lock_ok,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_flag,
  output logic       out_error,
  output logic       locked
);
  frame_kind_e kind;
  logic fire, is_data, rsvd, base_err, rep_err, nxt_flag, nxt_err;

  always_comb begin
    kind     = frame_kind_e'(in_kind);
    is_data  = (kind == FK_DATA);
    rsvd     = (kind == FK_RSVD);
    fire     = in_valid && in_ready;
    base_err = in_code_err || rsvd;
    nxt_err  = base_err || rep_err;
    nxt_flag = is_data ? in_flag : 1'b0;
  end

  rxfc_parity u_parity (
    .clk(clk), .rst_n(rst_n), .fire(fire), .alt_en(alt_check_en),
    .is_data(is_data), .flag(in_flag), .other_err(base_err),
    .repeat_err(rep_err)
  );

  rxfc_lock #(.RELOCK_FRAMES(RELOCK_FRAMES)) u_lock (
    .clk(clk), .rst_n(rst_n), .fire(fire), .lock_ok(lock_ok), .locked(locked)
  );

  rxfc_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .nxt_flag(nxt_flag), .nxt_error(nxt_err), .out_valid(out_valid),
    .out_ready(out_ready), .out_flag(out_flag), .out_error(out_error)
  );
endmodule

// File: rtl/rx_frame_checker_sva.sv
module rx_frame_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_kind,
  input logic       in_flag,
  input logic       in_code_err,
  input logic       lock_ok,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_flag,
  input logic       out_error,
  input logic       locked
);
  logic acc;
  always_comb acc = in_valid && in_ready;

  a_r2_code_err_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_code_err |=> out_valid && out_error);
  a_r3_fill_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_kind == 2'b10) |=> !out_flag);
  a_r4_data_flag_pass: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_kind == 2'b00) |=> out_flag == $past(in_flag));
  a_r9_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lock_ok |=> !locked);
  a_r9_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |=> !locked);
  a_r9_rise_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(acc) && $past(lock_ok));
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_flag) && $stable(out_error));
  a_r10_no_take_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  a_r11_rsvd_error: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_kind == 2'b11) |=> out_error && !out_flag);
endmodule

bind rx_frame_checker rx_frame_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .in_flag(in_flag), .in_code_err(in_code_err),
  .lock_ok(lock_ok), .out_valid(out_valid), .out_ready(out_ready),
  .out_flag(out_flag), .out_error(out_error), .locked(locked)
);

// File: tb/tb_rx_frame_checker.sv
module tb_rx_frame_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alt_check_en = 1'b0, in_valid = 1'b0, in_flag = 1'b0, in_code_err = 1'b0;
  logic lock_ok = 1'b0, out_ready = 1'b1;
  logic [1:0] in_kind = 2'b00;
  logic in_ready, out_valid, out_flag, out_error, locked;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model state
  bit m_ov = 0, m_flag = 0, m_err = 0, m_locked = 0, m_have = 0, m_last = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  rx_frame_checker dut (
    .clk(clk), .rst_n(rst_n), .alt_check_en(alt_check_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_kind(in_kind), .in_flag(in_flag),
    .in_code_err(in_code_err), .lock_ok(lock_ok), .out_valid(out_valid),
    .out_ready(out_ready), .out_flag(out_flag), .out_error(out_error),
    .locked(locked)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "out_valid", out_valid, m_ov);
    chk(tag, "locked", locked, m_locked);
    chk(tag, "in_ready", in_ready, !m_ov || out_ready);
    if (m_ov) begin
      chk(tag, "out_flag", out_flag, m_flag);
      chk(tag, "out_error", out_error, m_err);
    end
  endtask

  // drive at negedge, advance model, compare at the following negedge
  task automatic step(bit alt, bit v, bit [1:0] k, bit f, bit ce, bit lk, bit ordy, string tag);
    bit fire, e;
    alt_check_en = alt; in_valid = v; in_kind = k; in_flag = f;
    in_code_err = ce; lock_ok = lk; out_ready = ordy;
    fire = v && (!m_ov || ordy);
    if (fire) begin
      e = ce || (k == 2'b11) || (alt && k == 2'b00 && m_have && f == m_last);
      m_ov = 1; m_err = e; m_flag = (k == 2'b00) ? f : 1'b0;
      if (!alt || e) m_have = 0;
      else if (k == 2'b00) begin m_have = 1; m_last = f; end
      if (!lk) begin m_locked = 0; m_cnt = 0; end
      else if (!m_locked) begin
        m_cnt++;
        if (m_cnt >= 2) begin m_locked = 1; m_cnt = 0; end
      end
    end else if (ordy) m_ov = 0;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    chk("R1", "out_flag", out_flag, 1'b0);
    chk("R1", "out_error", out_error, 1'b0);
    // R9: gain lock
    step(0, 1, 2'b10, 1, 0, 1, 1, "R9_R3");
    step(0, 1, 2'b10, 0, 0, 1, 1, "R9");
    // R4 data flag passes through
    step(0, 1, 2'b00, 1, 0, 1, 1, "R4");
    step(0, 1, 2'b00, 1, 0, 1, 1, "R4_R5 no check in normal mode");
    step(0, 1, 2'b00, 0, 0, 1, 1, "R4");
    // R3 fill and control force zero
    step(0, 1, 2'b10, 1, 0, 1, 1, "R3 fill");
    step(0, 1, 2'b01, 1, 0, 1, 1, "R3 ctrl");
    // R2 then R8
    step(0, 1, 2'b00, 1, 1, 1, 1, "R2");
    step(0, 1, 2'b00, 0, 0, 1, 1, "R8");
    // R5 R6 R7 alternation
    step(1, 1, 2'b00, 0, 0, 1, 1, "R7 first sets reference");
    step(1, 1, 2'b00, 1, 0, 1, 1, "R5 toggle ok");
    step(1, 1, 2'b10, 1, 0, 1, 1, "R6 fill between");
    step(1, 1, 2'b01, 0, 0, 1, 1, "R6 ctrl between");
    step(1, 1, 2'b00, 1, 0, 1, 1, "R5_R6 repeat across fill");
    step(1, 1, 2'b00, 1, 0, 1, 1, "R7 resync after error");
    step(1, 1, 2'b00, 0, 0, 1, 1, "R5 toggle ok");
    step(1, 1, 2'b00, 0, 1, 1, 1, "R2_R5 code error and repeat together");
    step(1, 1, 2'b00, 0, 0, 1, 1, "R7 resync");
    step(1, 1, 2'b10, 0, 0, 1, 1, "R6");
    step(1, 1, 2'b00, 1, 0, 1, 1, "R6 toggle across fill");
    // R11 reserved
    step(1, 1, 2'b11, 1, 0, 1, 1, "R11");
    step(1, 1, 2'b00, 1, 0, 1, 1, "R11 resync");
    // R9 lock loss and relock
    step(1, 1, 2'b10, 0, 0, 0, 1, "R9 drop");
    step(1, 1, 2'b10, 0, 0, 1, 1, "R9 still low");
    step(1, 1, 2'b10, 0, 0, 1, 1, "R9 relock");
    // R10 back-pressure
    step(0, 1, 2'b00, 1, 0, 1, 0, "R10 load");
    step(0, 1, 2'b00, 0, 1, 0, 0, "R10 stall hold");
    step(0, 1, 2'b00, 0, 1, 0, 0, "R10 stall hold");
    step(0, 0, 2'b00, 0, 0, 1, 1, "R10 drain");
    step(0, 0, 2'b00, 0, 0, 1, 1, "R10 empty");
    // mixed pseudo-random stream
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom;
      step(r[0] | r[1], r[2] | r[3], r[5:4], r[6], (r[9:7] == 3'd0),
           (r[12:10] != 3'd0), (r[14:13] != 2'd0), "R2_R5_R9_R10 mixed");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule